// File: doc/BRIEF.md
# Multichannel Capture Sample Buffer

This block sits between a multichannel decimation filter and the system bus of an audio capture path. Each capture channel owns a short first-in first-out buffer. The filter side writes a sample by raising that channel's valid strobe together with the data. The consumer side drains one channel at a time: it names the channel, and in the same cycle it sees that channel's oldest sample and whether that sample is valid. The pop takes effect at the clock edge.

One watermark is shared by all channels. A channel asks for service when it is enabled and holds more entries than the watermark. The requests of all channels are ORed together. A two-bit select then steers the result to a DMA request line, to an interrupt line, or to neither.

Per channel, the block keeps a data-available flag and sticky overflow and underflow flags. The data-available flag behaves differently by mode. With DMA selected, it drops by itself once draining brings the channel back to the watermark. In every other mode it stays set until software writes 1 to clear it.

Top module: `mcap_buffer`

Stream rules. The push side has no back-pressure. A channel that is disabled ignores its strobe. A sample that arrives while its FIFO is full is lost. On the pop side, `pop_valid` is the handshake valid and `pop_en` is the ready. A pop made while `pop_valid` is low is an underflow.

## Requirements
- R1: Each of the NCH channels (default 8) has an independent FIFO of DEPTH entries (default 8) that returns samples in arrival order. `pop_data` and `pop_valid` are combinational views of the head of channel `pop_ch`. A pop with `pop_en` removes that head at the rising edge.
- R2: A push is taken only when the channel's bit in the `ch_en` mask is 1. A push to a disabled channel changes neither its fill level, its data nor its flags.
- R3: A push to an enabled channel that already holds DEPTH entries is dropped, unless the same channel is popped in the same cycle. A dropped push sets that channel's `ovf_flag` bit from the next cycle. The bit stays set until a 1 is written to the matching `ovf_clr` bit. A new overflow in the same cycle as the clear wins.
- R4: A pop from an empty channel leaves `pop_valid` at 0 and `pop_data` at zero. It sets that channel's `unf_flag` bit, which stays set until a 1 is written to the matching `unf_clr` bit.
- R5: The watermark resets to DEPTH-1 (7). A cycle with `wm_load` high loads `wm_value`, which takes effect from the next cycle.
- R6: A channel requests service when it is enabled and its fill level is strictly greater than the watermark.
- R7: The `req_sel` encoding is 2'b01 for DMA and 2'b10 for interrupt; 2'b00 (off) and 2'b11 (reserved) select neither. With 2'b01, `dma_req` is the OR of all channel requests and `irq_req` is 0. With 2'b10 the roles are swapped. With 2'b00 or 2'b11 both outputs are 0.
- R8: A channel whose request is active at a clock edge shows `data_avail` set after that edge. Setting wins over any clear in the same cycle.
- R9: While `req_sel` is not 2'b01, a set `data_avail` bit stays set whatever the fill level does. It clears only when the matching `avail_clr` bit is 1 and no request is active.
- R10: While `req_sel` is 2'b01, `data_avail` clears at the first edge where the channel's fill level is at or below the watermark. `avail_clr` has no effect in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_en | input | NCH | Channel enable mask, bit c enables channel c |
| req_sel | input | 2 | Service routing: 00 off, 01 DMA, 10 interrupt, 11 reserved |
| wm_load | input | 1 | Load strobe for the watermark |
| wm_value | input | log2(DEPTH) | New watermark value |
| push_valid | input | NCH | Per-channel sample strobe from the filter |
| push_data | input | NCH*DW | Per-channel samples, channel c in bits c*DW +: DW |
| pop_en | input | 1 | Pop request (ready) for channel pop_ch |
| pop_ch | input | log2(NCH) | Channel selected for reading |
| pop_data | output | DW | Head sample of pop_ch, zero when empty |
| pop_valid | output | 1 | pop_ch holds at least one sample |
| avail_clr | input | NCH | Write-1 clear of data_avail (non-DMA modes) |
| ovf_clr | input | NCH | Write-1 clear of ovf_flag |
| unf_clr | input | NCH | Write-1 clear of unf_flag |
| data_avail | output | NCH | Per-channel data-available flags |
| ovf_flag | output | NCH | Per-channel sticky overflow flags |
| unf_flag | output | NCH | Per-channel sticky underflow flags |
| dma_req | output | 1 | Routed service request, DMA line |
| irq_req | output | 1 | Routed service request, interrupt line |

## Verification
The main sweep crosses every watermark value with every fill level from empty to full on one channel. It reads both request lines under all four select codes. This separates an off-by-one in the greater-than comparison from a decode slip in the select field. Draining under DMA, and then under interrupt mode, shows whether the data-available flag clears itself or holds until the write-1 clear. Single-channel overfill and overdrain runs, and a push to a mask with the upper channels disabled, check ordering, dropping and sticky errors on their own. A burst that fills all channels at once, followed by an interleaved drain, checks that the channels stay independent.

// File: rtl/mcap_pkg.sv
package mcap_pkg;
  typedef enum logic [1:0] {
    SEL_OFF  = 2'b00,
    SEL_DMA  = 2'b01,
    SEL_IRQ  = 2'b10,
    SEL_RSVD = 2'b11
  } req_sel_e;
endpackage

// File: rtl/mcap_chan_fifo.sv
module mcap_chan_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic          ovf_evt,
  output logic          unf_evt
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] level_q;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign pop_ok  = pop && (level_q != '0);
  assign push_ok = push && ((level_q != LW'(DEPTH)) || pop_ok);
  assign ovf_evt = push && !push_ok;
  assign unf_evt = pop && !pop_ok;
  assign head    = (level_q != '0) ? mem[rd_ptr] : '0;
  assign level   = level_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + LW'(1);
        2'b01:   level_q <= level_q - LW'(1);
        default: level_q <= level_q;
      endcase
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LW'(DEPTH)); // R1
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q == LW'(DEPTH) && push && !pop) |=> (level_q == LW'(DEPTH))); // R3
  AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q == '0 && pop && !push) |=> (level_q == '0)); // R4
endmodule

// File: rtl/mcap_flags.sv
module mcap_flags
  import mcap_pkg::*;
#(
  parameter int NCH = 8,
  parameter int LW  = 4,
  parameter int WW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH*LW-1:0] levels,
  input  logic [WW-1:0]   wm,
  input  logic [NCH-1:0]  ch_en,
  input  logic [1:0]      req_sel,
  input  logic [NCH-1:0]  ovf_evt,
  input  logic [NCH-1:0]  unf_evt,
  input  logic [NCH-1:0]  avail_clr,
  input  logic [NCH-1:0]  ovf_clr,
  input  logic [NCH-1:0]  unf_clr,
  output logic [NCH-1:0]  chan_req,
  output logic [NCH-1:0]  data_avail,
  output logic [NCH-1:0]  ovf_flag,
  output logic [NCH-1:0]  unf_flag
);
  logic dma_mode;
  assign dma_mode = (req_sel == SEL_DMA);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [LW-1:0] lvl;
    logic          over;
    assign lvl         = levels[c*LW +: LW];
    assign over        = lvl > LW'(wm);
    assign chan_req[c] = ch_en[c] && over;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_avail[c] <= 1'b0;
        ovf_flag[c]   <= 1'b0;
        unf_flag[c]   <= 1'b0;
      end else begin
        if (chan_req[c])                   data_avail[c] <= 1'b1;
        else if (dma_mode && !over)        data_avail[c] <= 1'b0;
        else if (!dma_mode && avail_clr[c]) data_avail[c] <= 1'b0;

        if (ovf_evt[c])      ovf_flag[c] <= 1'b1;
        else if (ovf_clr[c]) ovf_flag[c] <= 1'b0;

        if (unf_evt[c])      unf_flag[c] <= 1'b1;
        else if (unf_clr[c]) unf_flag[c] <= 1'b0;
      end
    end

    AST_AVAIL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      chan_req[c] |=> data_avail[c]); // R8
    AST_AVAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (data_avail[c] && !dma_mode && !avail_clr[c]) |=> data_avail[c]); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag[c] && !ovf_clr[c]) |=> ovf_flag[c]); // R3
    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (unf_flag[c] && !unf_clr[c]) |=> unf_flag[c]); // R4
  end
endmodule

// File: rtl/mcap_router.sv
module mcap_router
  import mcap_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_req,
  input  logic [1:0]     req_sel,
  output logic           dma_req,
  output logic           irq_req
);
  logic any_req;
  assign any_req = |chan_req;

  always_comb begin
    dma_req = 1'b0;
    irq_req = 1'b0;
    case (req_sel_e'(req_sel))
      SEL_DMA: dma_req = any_req;
      SEL_IRQ: irq_req = any_req;
      default: ;
    endcase
  end

  AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_req && irq_req)); // R7
  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sel == 2'b11 || req_sel == 2'b00) |-> (!dma_req && !irq_req)); // R7
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_req == '0) |-> (!dma_req && !irq_req)); // R6
endmodule

// File: rtl/mcap_buffer.sv
module mcap_buffer
  import mcap_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DEPTH = 8,
  parameter int DW    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCH-1:0]             ch_en,
  input  logic [1:0]                 req_sel,
  input  logic                       wm_load,
  input  logic [$clog2(DEPTH)-1:0]   wm_value,
  input  logic [NCH-1:0]             push_valid,
  input  logic [NCH*DW-1:0]          push_data,
  input  logic                       pop_en,
  input  logic [$clog2(NCH)-1:0]     pop_ch,
  output logic [DW-1:0]              pop_data,
  output logic                       pop_valid,
  input  logic [NCH-1:0]             avail_clr,
  input  logic [NCH-1:0]             ovf_clr,
  input  logic [NCH-1:0]             unf_clr,
  output logic [NCH-1:0]             data_avail,
  output logic [NCH-1:0]             ovf_flag,
  output logic [NCH-1:0]             unf_flag,
  output logic                       dma_req,
  output logic                       irq_req
);
  localparam int WW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [WW-1:0]     wm_q;
  logic [NCH-1:0]    push_gated, pop_sel, ovf_evt, unf_evt, chan_req;
  logic [NCH*LW-1:0] levels;
  logic [DW-1:0]     heads [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wm_q <= WW'(DEPTH - 1);
    else if (wm_load) wm_q <= wm_value;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_fifo
    assign push_gated[c] = push_valid[c] && ch_en[c];
    assign pop_sel[c]    = pop_en && (pop_ch == ($clog2(NCH))'(c));

    mcap_chan_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_gated[c]),
      .push_data (push_data[c*DW +: DW]),
      .pop       (pop_sel[c]),
      .head      (heads[c]),
      .level     (levels[c*LW +: LW]),
      .ovf_evt   (ovf_evt[c]),
      .unf_evt   (unf_evt[c])
    );
  end

  assign pop_data  = heads[pop_ch];
  assign pop_valid = levels[pop_ch*LW +: LW] != '0;

  mcap_flags #(.NCH(NCH), .LW(LW), .WW(WW)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .levels     (levels),
    .wm         (wm_q),
    .ch_en      (ch_en),
    .req_sel    (req_sel),
    .ovf_evt    (ovf_evt),
    .unf_evt    (unf_evt),
    .avail_clr  (avail_clr),
    .ovf_clr    (ovf_clr),
    .unf_clr    (unf_clr),
    .chan_req   (chan_req),
    .data_avail (data_avail),
    .ovf_flag   (ovf_flag),
    .unf_flag   (unf_flag)
  );

  mcap_router #(.NCH(NCH)) u_router (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_req (chan_req),
    .req_sel  (req_sel),
    .dma_req  (dma_req),
    .irq_req  (irq_req)
  );

  AST_POP_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && !pop_valid) |-> (pop_data == '0)); // R4
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid == '0 && !pop_en) |=> (ovf_flag & ~$past(ovf_flag)) == '0); // R2
endmodule

// File: tb/mcap_buffer_bench.sv
module mcap_buffer_bench;
  localparam int NCH = 8, DEPTH = 8, DW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n;
  logic [NCH-1:0]   ch_en;
  logic [1:0]       req_sel;
  logic             wm_load;
  logic [2:0]       wm_value;
  logic [NCH-1:0]   push_valid;
  logic [NCH*DW-1:0] push_data;
  logic             pop_en;
  logic [2:0]       pop_ch;
  logic [DW-1:0]    pop_data;
  logic             pop_valid;
  logic [NCH-1:0]   avail_clr, ovf_clr, unf_clr;
  logic [NCH-1:0]   data_avail, ovf_flag, unf_flag;
  logic             dma_req, irq_req;

  mcap_buffer #(.NCH(NCH), .DEPTH(DEPTH), .DW(DW)) u_mcap_buffer (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .req_sel(req_sel),
    .wm_load(wm_load), .wm_value(wm_value), .push_valid(push_valid),
    .push_data(push_data), .pop_en(pop_en), .pop_ch(pop_ch),
    .pop_data(pop_data), .pop_valid(pop_valid), .avail_clr(avail_clr),
    .ovf_clr(ovf_clr), .unf_clr(unf_clr), .data_avail(data_avail),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag), .dma_req(dma_req),
    .irq_req(irq_req)
  );

  int total = 0, bad = 0;
  int lvl [NCH];
  logic [DW-1:0] q [NCH][DEPTH];
  logic [NCH-1:0] m_av, m_ovf, m_unf;
  int wm_m;
  int sn = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [NCH-1:0] r;
    r = '0;
    for (int c = 0; c < NCH; c++) r[c] = ch_en[c] && (lvl[c] > wm_m);
    chk({tag, " data_avail R8/R9/R10"}, 32'(data_avail), 32'(m_av));
    chk({tag, " ovf_flag R3"}, 32'(ovf_flag), 32'(m_ovf));
    chk({tag, " unf_flag R4"}, 32'(unf_flag), 32'(m_unf));
    chk({tag, " dma_req R6/R7"}, 32'(dma_req), 32'(req_sel == 2'b01 && r != '0));
    chk({tag, " irq_req R6/R7"}, 32'(irq_req), 32'(req_sel == 2'b10 && r != '0));
  endtask

  task automatic step(input logic [NCH-1:0] pv, input bit pe, input int pc,
                      input logic [NCH-1:0] aclr, input logic [NCH-1:0] oclr,
                      input logic [NCH-1:0] uclr, input bit wl, input int wv,
                      input string tag);
    logic [NCH-1:0] req_o;
    logic [DW-1:0]  ed;
    @(negedge clk);
    push_valid = pv;
    for (int c = 0; c < NCH; c++) push_data[c*DW +: DW] = DW'(sn * 8 + c);
    pop_en = pe; pop_ch = 3'(pc);
    avail_clr = aclr; ovf_clr = oclr; unf_clr = uclr;
    wm_load = wl; wm_value = 3'(wv);
    #1;
    if (pe) begin
      ed = (lvl[pc] > 0) ? q[pc][0] : '0;
      chk({tag, " pop_data R1/R4"}, 32'(pop_data), 32'(ed));
      chk({tag, " pop_valid R4"}, 32'(pop_valid), 32'(lvl[pc] > 0));
    end
    for (int c = 0; c < NCH; c++) req_o[c] = ch_en[c] && (lvl[c] > wm_m);
    @(posedge clk);
    for (int c = 0; c < NCH; c++) begin
      bit popok, pushen, pushok;
      popok  = pe && (pc == c) && (lvl[c] > 0);
      pushen = pv[c] && ch_en[c];
      pushok = pushen && ((lvl[c] < DEPTH) || popok);
      if (req_o[c]) m_av[c] = 1'b1;
      else if (req_sel == 2'b01 && !(lvl[c] > wm_m)) m_av[c] = 1'b0;
      else if (req_sel != 2'b01 && aclr[c]) m_av[c] = 1'b0;
      if (pushen && !pushok) m_ovf[c] = 1'b1;
      else if (oclr[c]) m_ovf[c] = 1'b0;
      if (pe && pc == c && lvl[c] == 0) m_unf[c] = 1'b1;
      else if (uclr[c]) m_unf[c] = 1'b0;
      if (popok) begin
        for (int i = 0; i < DEPTH - 1; i++) q[c][i] = q[c][i+1];
        lvl[c]--;
      end
      if (pushok) begin
        q[c][lvl[c]] = DW'(sn * 8 + c);
        lvl[c]++;
      end
    end
    if (wl) wm_m = wv;
    sn++;
    #1;
    push_valid = '0; pop_en = 1'b0; avail_clr = '0; ovf_clr = '0; unf_clr = '0;
    wm_load = 1'b0;
    #4;
    check_all(tag);
  endtask

  task automatic idle(input string tag);
    step('0, 1'b0, 0, '0, '0, '0, 1'b0, 0, tag);
  endtask
  task automatic pushn(input int c, input int n, input string tag);
    for (int k = 0; k < n; k++) step(NCH'(1) << c, 1'b0, 0, '0, '0, '0, 1'b0, 0, tag);
  endtask
  task automatic popn(input int c, input int n, input string tag);
    for (int k = 0; k < n; k++) step('0, 1'b1, c, '0, '0, '0, 1'b0, 0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ch_en = '0; req_sel = 2'b00; wm_load = 1'b0; wm_value = '0;
    push_valid = '0; push_data = '0; pop_en = 1'b0; pop_ch = '0;
    avail_clr = '0; ovf_clr = '0; unf_clr = '0;
    for (int c = 0; c < NCH; c++) lvl[c] = 0;
    m_av = '0; m_ovf = '0; m_unf = '0; wm_m = DEPTH - 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check_all("reset R5");

    // R5/R6: reset watermark 7 -> request only at 8 entries
    ch_en = 8'h01; req_sel = 2'b01;
    pushn(0, 7, "wm7 below R5");
    pushn(0, 1, "wm7 full R5");
    // R3: overfill drops and sticks
    pushn(0, 2, "overfill R3");
    idle("ovf sticky R3");
    step('0, 1'b0, 0, '0, 8'h01, '0, 1'b0, 0, "ovf clear R3");
    // R1/R4: order then overdrain
    popn(0, 10, "drain R1");
    step('0, 1'b0, 0, '0, '0, 8'h01, 1'b0, 0, "unf clear R4");

    // R2: disabled channels ignore pushes
    ch_en = 8'h0F;
    step(8'hFF, 1'b0, 0, '0, '0, '0, 1'b0, 0, "mask push R2");
    for (int c = 0; c < NCH; c++) popn(c, 1, "mask pop R2");
    step('0, 1'b0, 0, '0, '0, 8'hFF, 1'b0, 0, "unf clear R2");

    // R5/R6/R7/R10 sweep: every watermark x every fill x every select
    ch_en = 8'hFF;
    for (int w = 0; w < DEPTH; w++) begin
      step('0, 1'b0, 0, '0, '0, '0, 1'b1, w, "wm load R5");
      for (int f = 0; f <= DEPTH; f++) begin
        pushn(2, f, "sweep fill R6");
        for (int s = 0; s < 4; s++) begin
          req_sel = 2'(s);
          idle("sweep sel R7");
        end
        req_sel = 2'b01;
        popn(2, f, "sweep drain R10");
        idle("sweep settle R10");
        req_sel = 2'b00;
        step('0, 1'b0, 0, 8'hFF, '0, '0, 1'b0, 0, "sweep clr R9");
      end
    end

    // R9: interrupt mode keeps flag until write-1 clear
    req_sel = 2'b10;
    step('0, 1'b0, 0, '0, '0, '0, 1'b1, 3, "wm3 R5");
    pushn(3, 5, "irq fill R9");
    popn(3, 5, "irq drain R9");
    idle("irq hold R9");
    step('0, 1'b0, 0, 8'h08, '0, '0, 1'b0, 0, "irq clr R9");
    // R10: DMA mode self-clears, avail_clr ignored while set
    req_sel = 2'b01;
    pushn(3, 5, "dma fill R10");
    step('0, 1'b0, 0, 8'h08, '0, '0, 1'b0, 0, "dma clr ignored R10");
    popn(3, 2, "dma drain R10");
    idle("dma settle R10");

    // R1/R3: all channels at once, then interleaved drain
    for (int k = 0; k < DEPTH + 1; k++) step(8'hFF, 1'b0, 0, '0, '0, '0, 1'b0, 0, "burst R3");
    for (int k = 0; k < DEPTH + 1; k++)
      for (int c = 0; c < NCH; c++) popn(c, 1, "interleave R1");
    idle("end R4");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule